// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the protocol side of a two-wire serial EEPROM that holds 2048 bytes. It runs on a system clock. It oversamples the bus clock and data lines and finds start and stop conditions. It shifts words in and out one bit per bus clock, and it acknowledges on the ninth clock by pulling the data line low. It never drives the data line high.

The storage array, the page latch and the self-timed programming timer sit outside the block:

- **Reads:** the block presents an address and takes back the byte at that address in the same cycle.
- **Writes:** it issues a one-cycle write strobe for each received data byte.
- **Programming:** it raises a one-cycle commit pulse when a write transaction ends cleanly.
- **Busy:** the external timer reports that it is busy through `wr_busy`.

The device word carries three strap bits and three high address bits. One strap bit is compared in inverted form. A single 11-bit address counter serves every access and keeps its value between transactions. A write sequence, a random read, a current-address read and a sequential read all work from that counter.

Top module: `ee_twi_slave`

## Requirements
- R1: After a synchronous reset, `sda_oe`, `mem_we` and `wr_commit` are 0 and the address counter (seen on `mem_addr`) is 0.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. `sda_oe` (1 = pull low) changes only while the clock line is low, and it is 0 whenever the block is idle.
- R3: A device word, received MSB first, matches when bit 7 = 1, bit 6 = `strap[2]`, bit 5 = NOT `strap[1]` and bit 4 = `strap[0]`. Bit 0 = 1 selects a read. On a match the block pulls the line low during the ninth clock.
- R4: A device word that does not match gets no acknowledge. Every later byte up to the next start is ignored: no acknowledge and no write strobe.
- R5: In a write, the byte after the device word is the low 8 address bits and device-word bits 3:1 are the top 3. Each following data byte is acknowledged and given one `mem_we` pulse at the current address.
- R6: After each written byte only the low 4 address bits advance, so writing past the end of a 16-byte page wraps to its start.
- R7: A stop at a byte boundary after at least one data byte gives a single-cycle `wr_commit`. A stop that arrives partway through a data byte gives none.
- R8: A current-address read returns the byte at the counter, which holds the last accessed address plus one. The block bits of a read device word are ignored.
- R9: A read continues to the next byte while the master acknowledges. The read address wraps from 2047 to 0. A missing master acknowledge ends the read and releases the line.
- R10: A random read is a device word and word address with no data, then a repeated start and a read device word. It returns the byte at the loaded address.
- R11: While `wr_busy` is 1 the device word is not acknowledged. Once `wr_busy` is 0 it is acknowledged again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap | input | 3 | Device select straps |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | 11 | Address counter / array address |
| mem_rdata | input | 8 | Array byte at `mem_addr` |
| mem_we | output | 1 | One-cycle write strobe per data byte |
| mem_wdata | output | 8 | Byte written with `mem_we` |
| wr_commit | output | 1 | Start programming of latched bytes |
| wr_busy | input | 1 | Programming timer running |

## Verification
A corrupted protocol state shows at the ports within one byte time, which is nine bus clocks: an acknowledge goes missing or appears where it should not, or a write strobe is dropped or doubled. A wrong address counter stays hidden until the next read or write, so each write is followed by a read of the same or the next address. Wrap errors appear only at a page end or at the top of memory, so transfers are placed across both boundaries.

// File: rtl/ee_twi_pkg.sv
package ee_twi_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WORD,
        ST_DATA,
        ST_ACK,
        ST_TX,
        ST_RACK
    } ee_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // device word check: fixed marker, two straps as given, middle one inverted
    function automatic logic dev_match(input logic [BYTE_W-1:0] w, input logic [2:0] strap);
        return w[7] && (w[6] == strap[2]) && (w[5] == ~strap[1]) && (w[4] == strap[0]);
    endfunction

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync
    import ee_twi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.rise  = scl_s & ~scl_p;
        ev.fall  = ~scl_s & scl_p;
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              inc_rd,
    input  logic              inc_wr,
    output logic [ADDR_W-1:0] addr
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic [ROW_W-1:0]  row;
    logic [PAGE_W-1:0] col;

    assign row = addr[ADDR_W-1:PAGE_W];
    assign col = addr[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)         addr <= '0;
        else if (ld)     addr <= ld_val;
        else if (inc_rd) addr <= addr + 1'b1;            // whole-array wrap
        else if (inc_wr) addr <= {row, col + 1'b1};      // wrap inside page
    end

endmodule

// File: rtl/ee_twi_slave.sv
module ee_twi_slave
    import ee_twi_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              wr_commit,
    input  logic              wr_busy
);
    localparam int BLK_W = ADDR_W - BYTE_W;

    bus_ev_t            ev;
    ee_state_e          st, ack_nxt;
    logic [3:0]         cnt;
    logic [BYTE_W-1:0]  shreg;
    logic [BLK_W-1:0]   blk_q;
    logic               have_data;
    logic               mack;
    logic               ctr_ld, rd_inc;
    logic [ADDR_W-1:0]  ld_val;

    ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    // write strobe advances the counter one cycle later, so mem_addr is valid with mem_we
    ee_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .ld     (ctr_ld),
        .ld_val (ld_val),
        .inc_rd (rd_inc),
        .inc_wr (mem_we),
        .addr   (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ack_nxt   <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            blk_q     <= '0;
            have_data <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            wr_commit <= 1'b0;
            ctr_ld    <= 1'b0;
            ld_val    <= '0;
            rd_inc    <= 1'b0;
        end else begin
            mem_we    <= 1'b0;
            wr_commit <= 1'b0;
            ctr_ld    <= 1'b0;
            rd_inc    <= 1'b0;
            if (ev.start) begin
                st        <= ST_DEV;
                cnt       <= '0;
                sda_oe    <= 1'b0;
                have_data <= 1'b0;
            end else if (ev.stop) begin
                // clean end only if at most the stop's own setup bit was shifted
                if (st == ST_DATA && have_data && cnt <= 4'd1)
                    wr_commit <= 1'b1;
                st        <= ST_IDLE;
                sda_oe    <= 1'b0;
                have_data <= 1'b0;
            end else if (ev.rise) begin
                unique case (st)
                    ST_DEV, ST_WORD, ST_DATA: if (cnt < 4'd8) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        cnt   <= cnt + 4'd1;
                    end
                    ST_TX:   if (cnt < 4'd8) cnt <= cnt + 4'd1;
                    ST_RACK: mack <= ~ev.sda;
                    default: ;
                endcase
            end else if (ev.fall) begin
                unique case (st)
                    ST_DEV: if (cnt == 4'd8) begin
                        if (dev_match(shreg, strap) && !wr_busy) begin
                            sda_oe  <= 1'b1;
                            blk_q   <= shreg[BLK_W:1];
                            ack_nxt <= shreg[0] ? ST_TX : ST_WORD;
                            st      <= ST_ACK;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    ST_WORD: if (cnt == 4'd8) begin
                        sda_oe  <= 1'b1;
                        ctr_ld  <= 1'b1;
                        ld_val  <= {blk_q, shreg};
                        ack_nxt <= ST_DATA;
                        st      <= ST_ACK;
                    end
                    ST_DATA: if (cnt == 4'd8) begin
                        sda_oe    <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_wdata <= shreg;
                        have_data <= 1'b1;
                        ack_nxt   <= ST_DATA;
                        st        <= ST_ACK;
                    end
                    ST_ACK: begin
                        cnt <= '0;
                        st  <= ack_nxt;
                        if (ack_nxt == ST_TX) begin
                            shreg  <= mem_rdata;
                            sda_oe <= ~mem_rdata[BYTE_W-1];
                            rd_inc <= 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            st     <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (mack) begin
                            cnt    <= '0;
                            shreg  <= mem_rdata;
                            sda_oe <= ~mem_rdata[BYTE_W-1];
                            rd_inc <= 1'b1;
                            st     <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: the data line is only touched while the synchronised clock line is low
    p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);

    // R5: each received byte gives exactly one strobe cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R6: after a strobe the counter row is kept and the column steps by one
    p_page_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]))
                && (mem_addr[PAGE_W-1:0] == PAGE_W'($past(mem_addr[PAGE_W-1:0]) + 1'b1)));

    // R7: commit is a single-cycle pulse
    p_commit_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

    // R11: no device-word acknowledge while programming is busy
    p_no_ack_busy_r11: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && $past(st) == ST_DEV) |-> !$past(wr_busy));

endmodule

// File: tb/ee_twi_slave_tb.sv
`timescale 1ns/1ps
module ee_twi_slave_tb;
    localparam int AW = 11;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0]    strap = 3'b101;
    logic          wr_busy = 1'b0;
    logic          sda_oe, mem_we, wr_commit;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata, mem_wdata;
    wire           sda_line = sda_m & ~sda_oe;

    logic [7:0]    mem [0:2047];
    logic [AW-1:0] we_log [0:15];
    int            we_cnt = 0, commit_cnt = 0;
    int            checks = 0, fails = 0;
    logic [7:0]    wbuf [0:3];
    logic [7:0]    rbuf [0:3];

    always #2.5 clk = ~clk;

    ee_twi_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap(strap),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .wr_commit(wr_commit), .wr_busy(wr_busy)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2048; i++) mem[i] <= pat(i);
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            if (we_cnt < 16) we_log[we_cnt] <= mem_addr;
            we_cnt <= we_cnt + 1;
        end
    end

    always @(posedge clk) if (wr_commit) commit_cnt <= commit_cnt + 1;

    function automatic logic [7:0] devw(input logic [2:0] blk, input bit rd);
        return {1'b1, strap[2], ~strap[1], strap[0], blk, rd};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; tk(H); scl_m = 1'b1; tk(H); sda_m = 1'b0; tk(H); scl_m = 1'b0; tk(H);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tk(H); scl_m = 1'b1; tk(H); sda_m = 1'b1; tk(H);
    endtask

    task automatic sbit(input bit b);
        sda_m = b; tk(H); scl_m = 1'b1; tk(H); scl_m = 1'b0; tk(H);
    endtask

    task automatic sbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) sbit(b[i]);
        sda_m = 1'b1; tk(H); scl_m = 1'b1; tk(H/2);
        ack = (sda_line == 1'b0);
        tk(H/2); scl_m = 1'b0; tk(H);
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tk(H); scl_m = 1'b1; tk(H/2);
            b = {b[6:0], sda_line};
            tk(H/2); scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        tk(H); scl_m = 1'b1; tk(H); scl_m = 1'b0; sda_m = 1'b1; tk(H);
    endtask

    task automatic wr_seq(input logic [AW-1:0] a, input int n, output bit ok);
        bit ak;
        bstart();
        sbyte(devw(a[10:8], 1'b0), ak); ok = ak;
        sbyte(a[7:0], ak); ok &= ak;
        for (int i = 0; i < n; i++) begin sbyte(wbuf[i], ak); ok &= ak; end
        bstop(); tk(2*H);
    endtask

    task automatic rd_seq(input bit rnd, input logic [AW-1:0] a, input logic [2:0] blk,
                          input int n, output bit ok);
        bit ak;
        ok = 1'b1;
        if (rnd) begin
            bstart();
            sbyte(devw(a[10:8], 1'b0), ak); ok &= ak;
            sbyte(a[7:0], ak); ok &= ak;
        end
        bstart();
        sbyte(devw(blk, 1'b1), ak); ok &= ak;
        for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
        bstop(); tk(2*H);
    endtask

    localparam logic [18:0] VEC [0:5] = '{
        {11'h000, 8'hA5}, {11'h0FF, 8'h3C}, {11'h123, 8'h00},
        {11'h4AA, 8'hFF}, {11'h5F0, 8'h81}, {11'h7A1, 8'h5E}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        bit ok, ak;
        int c0, m0;
        logic [7:0] junk;
        tk(10);
        // R1 reset state
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 wr_commit", wr_commit, 0);
        chk("R1 mem_addr", mem_addr, 0);
        rst = 1'b0; tk(10);

        // table: byte write then random read of each entry
        for (int v = 0; v < 6; v++) begin
            c0 = we_cnt; m0 = commit_cnt;
            wbuf[0] = VEC[v][7:0];
            wr_seq(VEC[v][18:8], 1, ok);
            chk("R3 write acks", ok, 1);
            chk("R5 strobe count", we_cnt - c0, 1);
            chk("R5 strobe address", we_log[c0], VEC[v][18:8]);
            chk("R7 commit after stop", commit_cnt - m0, 1);
            rd_seq(1'b1, VEC[v][18:8], 3'b000, 1, ok);
            chk("R10 random read acks", ok, 1);
            chk("R10 random read data", rbuf[0], VEC[v][7:0]);
        end
        chk("R2 line released idle", sda_oe, 0);

        // R6 page wrap across a 16-byte page end
        c0 = we_cnt;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_seq(11'h34E, 4, ok);
        chk("R6 page acks", ok, 1);
        chk("R6 addr 0", we_log[c0],     11'h34E);
        chk("R6 addr 1", we_log[c0 + 1], 11'h34F);
        chk("R6 addr 2 wrapped", we_log[c0 + 2], 11'h340);
        chk("R6 addr 3", we_log[c0 + 3], 11'h341);
        rd_seq(1'b1, 11'h340, 3'b000, 2, ok);
        chk("R6 readback 340", rbuf[0], 8'h33);
        chk("R6 readback 341", rbuf[1], 8'h44);
        rd_seq(1'b1, 11'h34E, 3'b000, 1, ok);
        chk("R6 readback 34E", rbuf[0], 8'h11);

        // R8 current-address reads, block bits ignored
        rd_seq(1'b0, '0, 3'b110, 1, ok);
        chk("R8 current ack", ok, 1);
        chk("R8 current data", rbuf[0], 8'h22);
        rd_seq(1'b0, '0, 3'b001, 1, ok);
        chk("R8 current next", rbuf[0], pat(11'h350));

        // R9 sequential read across top of memory
        rd_seq(1'b1, 11'h7FE, 3'b000, 3, ok);
        chk("R9 seq 7FE", rbuf[0], pat(11'h7FE));
        chk("R9 seq 7FF", rbuf[1], pat(11'h7FF));
        chk("R9 seq wrap 000", rbuf[2], 8'hA5);
        chk("R9 released after nack", sda_oe, 0);
        rd_seq(1'b0, '0, 3'b000, 1, ok);
        chk("R9 counter after wrap", rbuf[0], pat(1));

        // R4 mismatch: middle strap compared non-inverted
        c0 = we_cnt; m0 = commit_cnt;
        bstart();
        sbyte(8'hD0, ak); chk("R4 no ack device", ak, 0);
        sbyte(8'h10, ak); chk("R4 no ack word", ak, 0);
        sbyte(8'h99, ak); chk("R4 no ack data", ak, 0);
        bstop(); tk(2*H);
        chk("R4 no strobe", we_cnt - c0, 0);
        chk("R4 no commit", commit_cnt - m0, 0);

        // R3 other strap value
        strap = 3'b010;
        rd_seq(1'b0, '0, 3'b000, 1, ok);
        chk("R3 strap 010 ack", ok, 1);
        strap = 3'b101;

        // R11 busy polling
        wr_busy = 1'b1;
        bstart(); sbyte(devw(3'b000, 1'b1), ak); bstop(); tk(2*H);
        chk("R11 no ack while busy", ak, 0);
        wr_busy = 1'b0;
        bstart(); sbyte(devw(3'b000, 1'b1), ak); rbyte(1'b0, junk); bstop(); tk(2*H);
        chk("R11 ack after busy", ak, 1);

        // R7 abort: one full byte then a stop partway through the next byte
        c0 = we_cnt; m0 = commit_cnt;
        bstart();
        sbyte(devw(3'b001, 1'b0), ak);
        sbyte(8'h20, ak);
        sbyte(8'h77, ak);
        sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1);
        bstop(); tk(2*H);
        chk("R7 abort strobe", we_cnt - c0, 1);
        chk("R7 abort no commit", commit_cnt - m0, 0);
        chk("R2 released after abort", sda_oe, 0);

        report();
    end
endmodule